// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a small single-port static memory with a synchronous front end and a registered output stage. It is aimed at bus masters that fetch cache lines in groups of four words. The master presents one address together with an address strobe. The block then steps through the other three words of the aligned four-word group on its own, one word per clock, for as long as the advance input is held low. The order of those words is set by a static mode input. One setting wraps them in ascending order; the other forms them with an exclusive-or pattern.

Either of two strobes can load the address. The processor-side strobe only counts while the primary chip enable is active. The controller-side strobe always counts. Three chip enables, two active low and one active high, let several instances share a data bus. Each 32-bit word is written as four byte lanes, chosen by a byte-write enable with per-lane selects or by a global write that forces every lane. Read data passes through an array read register and then an output register, so the first word arrives three clocks after the address is presented. The data bus is split at the block boundary into an input word, an output word and an output-enable flag, which together model one shared pad bus.

Top module: `sync_burst_sram`

## Requirements
- R1: On a rising clock edge the address and chip-select state are loaded when `adsc_n` is low, or when `adsp_n` is low while `ce_n` is low. When `adsp_n` is low with `ce_n` high (and `adsc_n` high), nothing is loaded and any burst in progress continues.
- R2: Each load restarts the beat count at zero, even if a burst is in progress. The new address is read back starting from its own first word.
- R3: Between loads, the beat count goes up by one (modulo 4) only on edges where `adv_n` is low. The word address keeps its upper bits from the loaded address. Its low two bits are formed from the loaded low bits `s` and the count `k`: `s+k` modulo 4 when `burst_lin` is 1, and `s^k` when `burst_lin` is 0.
- R4: On an edge with no load while the block is selected, byte lane i (data bits 8i+7:8i) of the current word takes `din` if `gw_n` is low, or if `bwe_n` is low and `bw_n[i]` is low.
- R5: A lane whose `bw_n` bit is high keeps its contents under `bwe_n` low. With both `gw_n` and `bwe_n` high, no lane is written, whatever `bw_n` holds.
- R6: After a load at edge N, the first word is on `dout` with `dout_en` high after edge N+2 and not before. While `adv_n` stays low, each following word appears one edge later.
- R7: A load with `ce_n` high, `ce2_n` high or `ce2` low deselects the block. `dout_en` is low right after that edge, and no write takes effect until the next selecting load.
- R8: `dout_en` is low whenever `oe_n` is high, without waiting for a clock edge.
- R9: While `rst_n` is low, and after its release until a read completes, `dout_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address |
| adsp_n | input | 1 | Processor-side address strobe, active low, gated by `ce_n` |
| adsc_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2_n | input | 1 | Expansion chip enable, active low |
| ce2 | input | 1 | Expansion chip enable, active high |
| gw_n | input | 1 | Global write, all lanes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bw_n | input | 4 | Per-lane write selects, active low, bit i for bits 8i+7:8i |
| oe_n | input | 1 | Asynchronous output enable, active low |
| burst_lin | input | 1 | Burst order: 1 ascending wrap, 0 exclusive-or |
| din | input | 32 | Write data from the shared bus |
| dout | output | 32 | Read data to the shared bus |
| dout_en | output | 1 | Drive enable for the shared bus |

## Verification
Four-word write and read bursts run in both orders from each of the four start offsets. A wrong order or a wrong wrap shows up as a word from the wrong slot, because every address holds a distinct value. All sixteen byte-lane masks are written over a known background, together with global-write and no-enable cases, so that a lane-to-bit mismatch, a missing override or a stray write can each be told apart. Further sequences cover a gated processor strobe, a controller strobe that cuts a burst short, deselect by each of the three enables, and the asynchronous output enable. These separate a wrong latency, a strobe that is wrongly accepted and a late deselect.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  // low two bits of the word address for beat k of a burst starting at s
  function automatic logic [1:0] beat_offset(input logic [1:0] s,
                                             input logic [1:0] k,
                                             input logic       lin);
    beat_offset = lin ? 2'(s + k) : (s ^ k);
  endfunction

  // per-lane write enables from the write controls
  function automatic logic [3:0] lane_mask(input logic       gw_n,
                                           input logic       bwe_n,
                                           input logic [3:0] bw_n);
    if (!gw_n)       lane_mask = 4'hF;
    else if (!bwe_n) lane_mask = ~bw_n;
    else             lane_mask = 4'h0;
  endfunction

endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adsp_n,
  input  logic              adsc_n,
  input  logic              adv_n,
  input  logic              ce_n,
  input  logic              ce2_n,
  input  logic              ce2,
  input  logic              burst_lin,
  output logic              strobe,
  output logic              desel,
  output logic              sel_q,
  output logic [ADDR_W-1:0] cur_addr
);
  import sbs_pkg::*;

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              sel_d, sel_in, cnt_en;

  always_comb begin
    strobe = !adsc_n || (!adsp_n && !ce_n);
    sel_in = !ce_n && !ce2_n && ce2;
    desel  = strobe && !sel_in;
    cnt_en = strobe || !adv_n;
    base_d = strobe ? addr : base_q;
    sel_d  = strobe ? sel_in : sel_q;
    if (strobe)      cnt_d = 2'd0;
    else if (!adv_n) cnt_d = cnt_q + 2'd1;
    else             cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= 1'b0;
    end else if (strobe) begin
      base_q <= base_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= 2'd0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cur_addr = {base_q[ADDR_W-1 -: HI_W],
                     beat_offset(base_q[1:0], cnt_q, burst_lin)};

  AST_LOAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> cnt_q == 2'd0);                                     // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && adv_n) |=> $stable(cnt_q));                        // R3
  AST_ADSP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (adsc_n && ce_n) |=> ($stable(base_q) && $stable(sel_q)));     // R1

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    wr_go,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_go,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic              we;

    assign we = wr_go && lane_we[g];

    always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata[g*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rd_go) rd_data[g*LANE_W +: LANE_W] <= cells[addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= rd_go;
  end

endmodule

// File: rtl/sbs_out_stage.sv
module sbs_out_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_vld,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              kill,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  logic [DATA_W-1:0] out_q;
  logic              vld_q, vld_d;

  always_comb vld_d = kill ? 1'b0 : rd_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (rd_vld) out_q <= rd_data;
  end

  assign dout    = out_q;
  assign dout_en = vld_q && !oe_n;

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adsp_n,
  input  logic                    adsc_n,
  input  logic                    adv_n,
  input  logic                    ce_n,
  input  logic                    ce2_n,
  input  logic                    ce2,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    oe_n,
  input  logic                    burst_lin,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  import sbs_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  logic              strobe, desel, sel_q, wr_go, rd_go, rd_vld;
  logic [ADDR_W-1:0] cur_addr;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] rd_data;

  sbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n),
    .adsc_n(adsc_n), .adv_n(adv_n), .ce_n(ce_n), .ce2_n(ce2_n),
    .ce2(ce2), .burst_lin(burst_lin), .strobe(strobe), .desel(desel),
    .sel_q(sel_q), .cur_addr(cur_addr)
  );

  always_comb begin
    lane_we = lane_mask(gw_n, bwe_n, bw_n);
    wr_go   = !strobe && sel_q && (|lane_we);
    rd_go   = !strobe && sel_q && !(|lane_we);
  end

  sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .rst_n(rst_n), .addr(cur_addr), .wr_go(wr_go),
    .lane_we(lane_we), .wdata(din), .rd_go(rd_go),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  sbs_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_data(rd_data),
    .kill(desel), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  AST_DESEL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (desel && !oe_n) |=> !dout_en);                                // R7
  AST_STROBE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> ##1 !dout_en);                                      // R6

endmodule

// File: tb/tb_sync_burst_sram.sv
module tb_sync_burst_sram;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] addr;
  logic        adsp_n, adsc_n, adv_n, ce_n, ce2_n, ce2, gw_n, bwe_n, oe_n, burst_lin;
  logic [3:0]  bw_n;
  logic [31:0] din, dout;
  logic        dout_en;

  logic [31:0] ref_mem [DEPTH];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
    .adv_n(adv_n), .ce_n(ce_n), .ce2_n(ce2_n), .ce2(ce2), .gw_n(gw_n),
    .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .burst_lin(burst_lin),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    adsp_n = 1; adsc_n = 1; adv_n = 1; ce_n = 0; ce2_n = 0; ce2 = 1;
    gw_n = 1; bwe_n = 1; bw_n = 4'hF; oe_n = 0;
  endtask

  function automatic logic [AW-1:0] beat_addr(input logic [AW-1:0] a, input int k, input logic lin);
    logic [1:0] s, kk;
    s = a[1:0]; kk = 2'(k);
    return {a[AW-1:2], (lin ? 2'(s + kk) : (s ^ kk))};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic g, input logic be, input logic [3:0] b);
    logic [31:0] r;
    r = old;
    for (int i = 0; i < 4; i++)
      if (!g || (!be && !b[i])) r[8*i +: 8] = nw[8*i +: 8];
    return r;
  endfunction

  // R3 R4: four-beat global-write burst
  task automatic burst_write(input logic [AW-1:0] a, input logic lin, input logic [31:0] seed);
    @(negedge clk); burst_lin = lin; addr = a; adsp_n = 0;
    @(negedge clk); adsp_n = 1;
    for (int k = 0; k < 4; k++) begin
      gw_n = 0; adv_n = 0; din = seed + 32'(k);
      ref_mem[beat_addr(a, k, lin)] = din;
      @(negedge clk);
    end
    idle();
  endtask

  // R3 R6: four-beat read burst, latency and order
  task automatic burst_read(input logic [AW-1:0] a, input logic lin, input bit use_c);
    @(negedge clk); burst_lin = lin; addr = a;
    if (use_c) adsc_n = 0; else adsp_n = 0;
    @(negedge clk); adsc_n = 1; adsp_n = 1; adv_n = 0;
    @(negedge clk); chk("R6 no data one edge after read", 32'(dout_en), 32'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R6 beat valid", 32'(dout_en), 32'd1);
      chk("R3 beat order", dout, ref_mem[beat_addr(a, k, lin)]);
    end
    idle();
  endtask

  task automatic single_write(input logic [AW-1:0] a, input logic g, input logic be,
                              input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); addr = a; adsc_n = 0;
    @(negedge clk); adsc_n = 1; gw_n = g; bwe_n = be; bw_n = b; din = d; oe_n = 1;
    ref_mem[a] = merge(ref_mem[a], d, g, be, b);
    @(negedge clk); idle();
  endtask

  task automatic single_read(input logic [AW-1:0] a, input string req);
    @(negedge clk); addr = a; adsc_n = 0;
    @(negedge clk); adsc_n = 1;
    @(negedge clk);
    @(negedge clk);
    chk(req, dout, ref_mem[a]);
    chk(req, 32'(dout_en), 32'd1);
  endtask

  task automatic t_reset();
    idle(); addr = '0; din = '0; burst_lin = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset off", 32'(dout_en), 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after release", 32'(dout_en), 32'd0);
  endtask

  task automatic t_fill();
    for (int b = 0; b < DEPTH / 4; b++) burst_write(AW'(4 * b), 1'b1, 32'hA500_0000 + 32'(b << 8));
  endtask

  task automatic t_orders();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        burst_write(AW'(16 + 4 * m + s), 1'(m), 32'h3C00_0000 + 32'(m * 64 + s * 8));
        burst_read(AW'(16 + 4 * m + s), 1'(m), 1'(s[0]));
      end
  endtask

  task automatic t_lanes();
    for (int m = 0; m < 16; m++) begin
      single_write(AW'(32 + m), 1'b1, 1'b0, ~4'(m), 32'h1234_5678 ^ 32'(m * 32'h0101_0101));
      single_read(AW'(32 + m), "R4 lane mask");
    end
    single_write(AW'(48), 1'b0, 1'b0, 4'hF, 32'hCAFE_F00D);
    single_read(AW'(48), "R4 global override");
    single_write(AW'(49), 1'b1, 1'b1, 4'h0, 32'hDEAD_BEEF);
    single_read(AW'(49), "R5 no enable no write");
    single_write(AW'(50), 1'b1, 1'b0, 4'hF, 32'h0BAD_0BAD);
    single_read(AW'(50), "R5 all lanes masked");
  endtask

  task automatic t_adsp_gated();
    @(negedge clk); addr = AW'(5); adsc_n = 0;
    @(negedge clk); adsc_n = 1; adsp_n = 0; ce_n = 1; addr = AW'(60);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R1 gated strobe ignored", dout, ref_mem[5]);
    chk("R1 gated strobe ignored en", 32'(dout_en), 32'd1);
  endtask

  task automatic t_override();
    @(negedge clk); burst_lin = 1; addr = AW'(8); adsc_n = 0;
    @(negedge clk); adsc_n = 1; adv_n = 0;
    @(negedge clk); adsc_n = 0; addr = AW'(21); adv_n = 1;
    @(negedge clk); adsc_n = 1;
    chk("R6 first word before override", dout, ref_mem[8]);
    @(negedge clk);
    @(negedge clk);
    chk("R2 override restarts", dout, ref_mem[21]);
    idle();
  endtask

  task automatic t_deselect();
    for (int kind = 0; kind < 3; kind++) begin
      single_read(AW'(kind + 1), "R6 single read");
      @(negedge clk); adsc_n = 0;
      if (kind == 0) ce_n = 1; else if (kind == 1) ce2_n = 1; else ce2 = 0;
      @(negedge clk); idle();
      chk("R7 deselect off", 32'(dout_en), 32'd0);
      gw_n = 0; din = 32'h5555_AAAA; oe_n = 1;
      @(negedge clk); idle();
      @(negedge clk);
      chk("R7 still off", 32'(dout_en), 32'd0);
    end
    single_read(AW'(1), "R7 no write while deselected");
    single_read(AW'(3), "R7 no write while deselected");
  endtask

  task automatic t_oe();
    single_read(AW'(7), "R8 setup");
    oe_n = 1; #1;
    chk("R8 oe off", 32'(dout_en), 32'd0);
    oe_n = 0; #1;
    chk("R8 oe on", 32'(dout_en), 32'd1);
  endtask

  initial begin
    t_reset();
    t_fill();
    t_orders();
    t_lanes();
    t_adsp_gated();
    t_override();
    t_deselect();
    t_oe();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule